// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates fifteen maskable interrupt sources for a small 8-bit processor core and gives the core a call request along with the address of the service routine. Each source has a pending flag, an enable bit and a one-bit priority select that chooses the low or the high level. A global enable gates every source. Reset is not handled here. It always vectors to address 0x0000. Within a level, the source with the lower index wins. A high-level request may interrupt a low-level routine. A request at the same level as the running routine, or at a lower level, waits until that routine returns.

The core tells the block about three events. `insn_done_i` marks an instruction boundary. `reti_i` marks that a return-from-interrupt has been decoded, and the return instruction completes at the next boundary. `ack_i` accepts a call. The block arbitrates only at a boundary. It presents the call in the cycle after that boundary and holds the call until the core acknowledges it. Two active-level bits track nesting. After a return, one full instruction must complete before any new call can be taken.

The controller state machine has three states:
- `ST_RUN`: normal execution.
- `ST_RETI_WAIT`: a return is in flight, so the next boundary is the return's own boundary.
- `ST_CALL`: a call is presented.

It has four transitions:
- RUN→RETI_WAIT on `reti_i`. This has priority over a boundary in the same cycle.
- RUN→CALL on a boundary with an eligible winner.
- RETI_WAIT→RUN on the next boundary, with no arbitration.
- CALL→RUN on `ack_i`.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, `call_req_o` is 0, `active_o` is 2'b00, `vector_o` is 0x0000 and `call_hi_o` is 0.
- R2: A source is eligible only when its pending bit, its enable bit and `gie_i` are all 1. With `gie_i` at 0, or with the source's enable at 0, no call is made for it.
- R3: Among eligible sources at the same level, the lowest index wins.
- R4: When both levels have eligible sources and no level is active, the high level wins. `prio_i` bit n = 1 selects high for source n.
- R5: When `active_o[0]` (low active) is set, only high-level sources are accepted. When `active_o[1]` (high active) is set, no source is accepted.
- R6: The winning source n gives `vector_o` = 0x0003 + 8·n on 16 bits. `call_hi_o` is 1 for a high-level winner.
- R7: Arbitration happens only at a cycle with `insn_done_i`=1 in RUN with `reti_i`=0. `call_req_o` rises in the following cycle. Vector and level stay stable until `ack_i`.
- R8: `ack_i` during a call sets the active bit of the serviced level, and `call_req_o` is 0 in the next cycle.
- R9: `reti_i` in RUN clears `active_o[1]` if it is set, and clears `active_o[0]` otherwise.
- R10: After `reti_i`, the next boundary takes no interrupt. The boundary after that may take one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 15 | Pending flags, bit n = source n |
| en_i | input | 15 | Per-source enable |
| prio_i | input | 15 | Per-source level, 1 = high |
| gie_i | input | 1 | Global enable |
| insn_done_i | input | 1 | Instruction boundary |
| reti_i | input | 1 | Return-from-interrupt decoded |
| ack_i | input | 1 | Core accepts the call |
| call_req_o | output | 1 | Call request |
| vector_o | output | 16 | Service routine address |
| call_hi_o | output | 1 | Level of the presented call |
| active_o | output | 2 | Active levels, [1] high, [0] low |

## Verification
The bench targets several ways the controller could go wrong, each with a visible symptom:
- Simultaneous requests at both levels: an encoder that scans from the wrong end, or ignores the level, presents the wrong vector.
- Preemption of a low routine by a high request, and a same-level request arriving during a routine: a controller that does not track nesting either refuses the preemption or lets the same-level request nest.
- A boundary right after a return: a design without the one-instruction rule raises a call one boundary early.
- A call held without acknowledgement: a design without the hold drops the call or lets the vector drift.
- Vectors for every source: a wrong stride or base shows up as an address mismatch.

Random traffic is compared against a cycle model of the requirements.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_RETI_WAIT = 2'd1,
        ST_CALL      = 2'd2
    } irqv_state_e;

    localparam int LVL_CNT = 2;
    localparam int LVL_LO  = 0;
    localparam int LVL_HI  = 1;
endpackage

// File: rtl/irqv_pick.sv
module irqv_pick #(
    parameter int N  = 15,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqv_nest.sv
module irqv_nest (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic       set_hi_i,
    input  logic       clr_i,
    output logic [1:0] act_o
);
    logic [1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 2'b00;
        end else if (set_i) begin
            act_q[set_hi_i] <= 1'b1;
        end else if (clr_i) begin
            if (act_q[1]) act_q[1] <= 1'b0;
            else          act_q[0] <= 1'b0;
        end
    end

    assign act_o = act_q;

    assert_set_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && set_hi_i) |=> act_q[1]);
    assert_set_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !set_hi_i) |=> act_q[0]);
    assert_clear_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && act_q[1]) |=> (!act_q[1] && act_q[0] == $past(act_q[0])));
    assert_clear_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && !act_q[1]) |=> (act_q == 2'b00));
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int N_SRC      = 15,
    parameter int VEC_W      = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] prio_i,
    input  logic             gie_i,
    input  logic             insn_done_i,
    input  logic             reti_i,
    input  logic             ack_i,
    output logic             call_req_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             call_hi_o,
    output logic [1:0]       active_o
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [VEC_W-1:0] VEC_LAST =
        VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(N_SRC - 1);

    irqv_state_e state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             lvl_q;

    logic [N_SRC-1:0] elig;
    logic [N_SRC-1:0] lvl_req   [LVL_CNT];
    logic             lvl_found [LVL_CNT];
    logic [IW-1:0]    lvl_idx   [LVL_CNT];

    logic             allow_hi, allow_lo, sel_hi, sel_lo, take;
    logic [IW-1:0]    win_idx;
    logic [VEC_W-1:0] win_vec;
    logic             nest_set, nest_clr;

    // eligibility and per-level selection
    assign elig = pend_i & en_i & {N_SRC{gie_i}};
    assign lvl_req[LVL_HI] = elig & prio_i;
    assign lvl_req[LVL_LO] = elig & ~prio_i;

    for (genvar g = 0; g < LVL_CNT; g++) begin : g_level
        irqv_pick #(.N(N_SRC), .IW(IW)) u_pick (
            .req_i   (lvl_req[g]),
            .found_o (lvl_found[g]),
            .idx_o   (lvl_idx[g])
        );
    end

    assign allow_hi = !active_o[1];
    assign allow_lo = !active_o[1] && !active_o[0];
    assign sel_hi   = allow_hi && lvl_found[LVL_HI];
    assign sel_lo   = allow_lo && lvl_found[LVL_LO] && !sel_hi;
    assign win_idx  = sel_hi ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
    assign win_vec  = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(win_idx);
    assign take     = (state_q == ST_RUN) && insn_done_i && !reti_i && (sel_hi || sel_lo);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (reti_i)    state_d = ST_RETI_WAIT;
                else if (take) state_d = ST_CALL;
            end
            ST_RETI_WAIT: begin
                if (insn_done_i) state_d = ST_RUN;
            end
            ST_CALL: begin
                if (ack_i) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register and latched call data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            vec_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                vec_q <= win_vec;
                lvl_q <= sel_hi;
            end
        end
    end

    assign nest_set = (state_q == ST_CALL) && ack_i;
    assign nest_clr = (state_q == ST_RUN) && reti_i;

    irqv_nest u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (nest_set),
        .set_hi_i (lvl_q),
        .clr_i    (nest_clr),
        .act_o    (active_o)
    );

    // outputs
    always_comb begin
        call_req_o = (state_q == ST_CALL);
        vector_o   = vec_q;
        call_hi_o  = lvl_q;
    end

    assert_call_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req_o && !ack_i) |=> (call_req_o && $stable(vector_o) && $stable(call_hi_o)));
    assert_no_call_off_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req_o && !(insn_done_i && !reti_i)) |=> !call_req_o);
    assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req_o && ack_i) |=> !call_req_o);
    assert_level_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> (!active_o[1] && (call_hi_o || !active_o[0])));
    assert_vector_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> (vector_o >= VEC_W'(VEC_BASE) && vector_o <= VEC_LAST &&
                        ((vector_o - VEC_W'(VEC_BASE)) % VEC_W'(VEC_STRIDE)) == '0));
    assert_one_insn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETI_WAIT) |=> !call_req_o);
endmodule

// File: tb/irqv_ctrl_test.sv
`timescale 1ns/1ps
module irqv_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] pend = '0, en = '0, prio = '0;
    logic        gie = 1'b0, insn = 1'b0, reti = 1'b0, ack = 1'b0;
    logic        call_req, call_hi;
    logic [15:0] vector;
    logic [1:0]  active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    int          m_st;   // 0 run, 1 after-return wait, 2 call presented
    logic [1:0]  m_act;
    logic [15:0] m_vec;
    logic        m_hi;

    always #10 clk = ~clk;

    irqv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
        .gie_i(gie), .insn_done_i(insn), .reti_i(reti), .ack_i(ack),
        .call_req_o(call_req), .vector_o(vector), .call_hi_o(call_hi),
        .active_o(active)
    );

    function automatic int lowest(input logic [14:0] r);
        for (int i = 0; i < 15; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] vec_for(input int n);
        return 16'(3 + 8 * n);
    endfunction

    task automatic model_step();
        logic [14:0] e;
        int h, l;
        e = pend & en & {15{gie}};
        h = lowest(e & prio);
        l = lowest(e & ~prio);
        case (m_st)
            0: begin
                if (reti) begin
                    if (m_act[1]) m_act[1] = 1'b0; else m_act[0] = 1'b0;
                    m_st = 1;
                end else if (insn) begin
                    if (!m_act[1] && h >= 0) begin
                        m_st = 2; m_vec = vec_for(h); m_hi = 1'b1;
                    end else if (m_act == 2'b00 && l >= 0) begin
                        m_st = 2; m_vec = vec_for(l); m_hi = 1'b0;
                    end
                end
            end
            1: if (insn) m_st = 0;
            default: if (ack) begin m_act[m_hi] = 1'b1; m_st = 0; end
        endcase
    endtask

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (req,vec,hi,active)", tag, act, exp);
        end
    endtask

    task automatic step(input logic [14:0] p, input logic [14:0] e, input logic [14:0] pr,
                        input logic g, input logic i, input logic r, input logic a,
                        input string tag);
        @(negedge clk);
        pend = p; en = e; prio = pr; gie = g; insn = i; reti = r; ack = a;
        model_step();
        @(posedge clk);
        #2;
        check(tag, {call_req, vector, call_hi, active},
              {(m_st == 2), m_vec, m_hi, m_act});
    endtask

    task automatic expect_out(input string tag, input logic c, input logic [15:0] v,
                              input logic [1:0] ac);
        check(tag, {call_req, (c ? vector : 16'h0), active}, {c, (c ? v : 16'h0), ac});
    endtask

    localparam logic [14:0] ALL = 15'h7fff;

    initial begin
        #(150_000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c0de));
        m_st = 0; m_act = 2'b00; m_vec = 16'h0; m_hi = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", {call_req, vector, call_hi, active}, 20'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: every source vector, enter and leave
        for (int n = 0; n < 15; n++) begin
            step(15'(1 << n), ALL, '0, 1, 1, 0, 0, "R6 vector");
            expect_out("R6 vector value", 1'b1, vec_for(n), 2'b00);
            step('0, ALL, '0, 1, 0, 0, 1, "R8 ack");
            expect_out("R8 active set", 1'b0, 16'h0, 2'b01);
            step('0, ALL, '0, 1, 0, 1, 0, "R9 return");
            step('0, ALL, '0, 1, 1, 0, 0, "R10 return boundary");
        end

        // R2: global and per-source gating
        step(15'h0010, ALL, '0, 0, 1, 0, 0, "R2 gie off");
        expect_out("R2 gie off no call", 1'b0, 16'h0, 2'b00);
        step(15'h0010, ~15'h0010, '0, 1, 1, 0, 0, "R2 enable off");
        expect_out("R2 enable off no call", 1'b0, 16'h0, 2'b00);

        // R7: no arbitration without a boundary
        step(15'h0010, ALL, '0, 1, 0, 0, 0, "R7 no boundary");
        expect_out("R7 no boundary no call", 1'b0, 16'h0, 2'b00);

        // R3: simultaneous same-level requests
        step(15'h0210, ALL, '0, 1, 1, 0, 0, "R3 simultaneous");
        expect_out("R3 lowest index wins", 1'b1, vec_for(4), 2'b00);
        // R7: hold without ack
        repeat (4) step(15'h0001, ALL, 15'h0001, 1, 1, 0, 0, "R7 hold");
        expect_out("R7 vector held", 1'b1, vec_for(4), 2'b00);
        step('0, ALL, '0, 1, 0, 0, 1, "R8 ack low");

        // R5: low active; same-level blocked, high preempts
        step(15'h0001, ALL, '0, 1, 1, 0, 0, "R5 same level");
        expect_out("R5 same level blocked", 1'b0, 16'h0, 2'b01);
        step(15'h0081, ALL, 15'h0080, 1, 1, 0, 0, "R5 preempt");
        expect_out("R5 high preempts low", 1'b1, vec_for(7), 2'b01);
        step('0, ALL, '0, 1, 0, 0, 1, "R8 ack high");
        expect_out("R8 both active", 1'b0, 16'h0, 2'b11);
        step(15'h0001, ALL, 15'h0001, 1, 1, 0, 0, "R5 high blocked");
        expect_out("R5 high blocked under high", 1'b0, 16'h0, 2'b11);

        // R9 and R10
        step(15'h0001, ALL, 15'h0001, 1, 1, 1, 0, "R9 reti clears high");
        expect_out("R9 high cleared", 1'b0, 16'h0, 2'b01);
        step(15'h0001, ALL, 15'h0001, 1, 1, 0, 0, "R10 return boundary");
        expect_out("R10 no call at return boundary", 1'b0, 16'h0, 2'b01);
        step(15'h0001, ALL, 15'h0001, 1, 1, 0, 0, "R10 one insn");
        expect_out("R10 call after one insn", 1'b1, vec_for(0), 2'b01);
        step('0, ALL, '0, 1, 0, 0, 1, "R8 ack");
        step('0, ALL, '0, 1, 0, 1, 0, "R9 reti");
        step('0, ALL, '0, 1, 0, 1, 0, "R9 reti");
        step('0, ALL, '0, 1, 1, 0, 0, "R10");
        step('0, ALL, '0, 1, 1, 1, 0, "R9 reti");
        step('0, ALL, '0, 1, 1, 0, 0, "R10");
        expect_out("R9 all cleared", 1'b0, 16'h0, 2'b00);

        // R4: high beats lower-index low
        step(15'h0201, ALL, 15'h0200, 1, 1, 0, 0, "R4 level first");
        expect_out("R4 high level wins", 1'b1, vec_for(9), 2'b00);
        step('0, ALL, '0, 1, 0, 0, 1, "R8 ack");

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            step(15'($urandom), ($urandom_range(0, 3) == 0) ? 15'($urandom) : ALL,
                 15'($urandom), ($urandom_range(0, 9) != 0), 1'($urandom),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0), "R5 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule